// File: doc/BRIEF.md
# Serial Line Service Scanner

This block watches a small group of serial line interfaces for lines that need attention. On a fixed period it takes a snapshot of which lines are requesting service. It then works through those lines from the lowest number to the highest. For each one it writes the line's live status word into that line's slot of a per-line table in memory. After that it reads the line's receive or transmit state number from the same slot and raises a one-cycle dispatch strobe. The strobe carries the line number, the direction and the state number, and the data handling for each state is left to the logic downstream.

A line requests service while its receive-data or transmit-empty flag is set. It also requests service once after its send indicator or its carrier detect drops, and once after software pokes it through the command port. The edge and poke requests are held until the scan that serves them. A poke makes the block refresh the stored status of an otherwise quiet line, so software can read it back from the table within the next scan period. State number zero means the line is discarding, and no strobe is raised for it.

Top module: `lsc_scanner`

## Requirements
- R1: While rst_ni is low, mem_we_o, mem_re_o and disp_valid_o are 0, and no request is held pending when reset is released.
- R2: A scan starts on the SCAN_CYC-th rising clock edge after reset release and on every SCAN_CYC-th edge after that, but only when enable_i is 1 and base_i is nonzero at that edge; otherwise no memory access or dispatch follows. The first status write of a scan is driven in the cycle right after the scan-start edge's following edge (edge k*SCAN_CYC + 1).
- R3: For each line served, the line's status word from line_status_i (bits [DW*l +: DW]) is written once to address base_i + 6*l + 1, whatever the cause of the request.
- R4: A line is requested when status bit 0 (receive data) or bit 1 (transmit empty) is 1 at the scan start, or after a 1-to-0 change of status bit 2 (send indicator) or bit 3 (carrier detect). A 0-to-1 change of bit 2 or bit 3 causes no request.
- R5: A cmd_we_i pulse with cmd_data_i bits [15:12] = 4'b1100, bits [8:0] = 0 and line number x in bits [11:9] (octal 14x000) makes line x request service in the next scan. Any other command value has no effect.
- R6: When a served line's status bit 0 is 1, the block reads address base_i + 6*l + 3 (data is expected on mem_rdata_i the cycle after mem_re_o). It then pulses disp_valid_o with disp_dir_o = 0, disp_line_o = l and disp_state_o = the word that was read.
- R7: When a served line's status bit 1 is 1, the block reads base_i + 6*l + 5 and pulses disp_valid_o with disp_dir_o = 1 and that word as the state.
- R8: A state word of 0 (discard mode) produces no dispatch for that direction.
- R9: Lines requesting in the same scan are served in ascending line number, and within a line the input dispatch comes before the output dispatch.
- R10: An edge or poke request is cleared when its line is served, so a single event yields exactly one status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Global scan enable |
| base_i | input | AW | Line table base address; zero blocks scanning |
| line_status_i | input | N_LINES*DW | Live status word of each line |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_data_i | input | 16 | Command word (poke encoding) |
| mem_we_o | output | 1 | Table write strobe |
| mem_re_o | output | 1 | Table read strobe |
| mem_addr_o | output | AW | Table word address |
| mem_wdata_o | output | DW | Status word being written |
| mem_rdata_i | input | DW | Read data, one cycle after mem_re_o |
| disp_valid_o | output | 1 | One-cycle dispatch strobe |
| disp_line_o | output | LW | Line being dispatched |
| disp_dir_o | output | 1 | 0 input, 1 output |
| disp_state_o | output | DW | State number read from the table |

## Verification
The bench builds the scanner with eight lines, 16-bit words and a 64-cycle scan period. A full scan of all eight lines with both directions takes at most 49 cycles, so it fits inside one period, and the bench can line up each stimulus with a known scan-start edge and keep each scan's results separate. With that short period the bench sweeps sixteen mixes of receive and transmit flags across all eight lines, with discard states placed on fixed lines. It also covers carrier and indicator edges in both directions, single and full-set pokes, and malformed commands. It predicts the order of writes and dispatches from the line numbers.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int CMD_W       = 16;
  localparam int ENTRY_WORDS = 6;
  localparam int OFF_STATUS  = 1;
  localparam int OFF_IN_ST   = 3;
  localparam int OFF_OUT_ST  = 5;
  localparam int ST_RXD      = 0;
  localparam int ST_TXE      = 1;
  localparam int ST_SIND     = 2;
  localparam int ST_CARR     = 3;
  localparam logic [3:0] POKE_OP = 4'b1100;

  typedef enum logic [2:0] {
    S_IDLE, S_SEL, S_WR, S_RD_IN, S_WT_IN, S_RD_OUT, S_WT_OUT
  } scan_st_e;
endpackage

// File: rtl/lsc_period_timer.sv
module lsc_period_timer #(
  parameter int PERIOD = 3800
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lsc_req_latch.sv
module lsc_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sind_i,
  input  logic carr_i,
  input  logic poke_i,
  input  logic clr_i,
  output logic pend_o
);
  logic sind_q, carr_q, set;

  // only a drop of either level raises a request
  assign set = (sind_q & ~sind_i) | (carr_q & ~carr_i) | poke_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sind_q <= 1'b0;
      carr_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      sind_q <= sind_i;
      carr_q <= carr_i;
      pend_o <= set | (pend_o & ~clr_i);
    end
  end
endmodule

// File: rtl/lsc_low_pick.sv
module lsc_low_pick #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [LW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = LW'(i);
      end
    end
  end
endmodule

// File: rtl/lsc_scanner.sv
module lsc_scanner
  import lsc_pkg::*;
#(
  parameter int N_LINES  = 8,
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int SCAN_CYC = 3800,
  localparam int LW      = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [AW-1:0]     base_i,
  input  logic [N_LINES*DW-1:0] line_status_i,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_data_i,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              disp_valid_o,
  output logic [LW-1:0]     disp_line_o,
  output logic              disp_dir_o,
  output logic [DW-1:0]     disp_state_o
);
  scan_st_e st_q;
  logic [N_LINES-1:0] pend, req, snap_q, clr;
  logic [LW-1:0] cur_q, pick_idx;
  logic pick_any, tick, in_q, out_q, poke_ok;
  logic [DW-1:0] stat_cur;
  logic [AW-1:0] word_off;

  lsc_period_timer #(.PERIOD(SCAN_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  assign poke_ok = cmd_we_i && (cmd_data_i[15:12] == POKE_OP) && (cmd_data_i[8:0] == '0);

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [DW-1:0] s;
    assign s = line_status_i[g*DW +: DW];
    lsc_req_latch u_lat (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sind_i(s[ST_SIND]),
      .carr_i(s[ST_CARR]),
      .poke_i(poke_ok && (cmd_data_i[11:9] == 3'(g))),
      .clr_i (clr[g]),
      .pend_o(pend[g])
    );
    assign req[g] = pend[g] | s[ST_RXD] | s[ST_TXE];
  end

  lsc_low_pick #(.N(N_LINES), .LW(LW)) u_pick (
    .vec_i(snap_q), .any_o(pick_any), .idx_o(pick_idx)
  );

  always_comb begin
    clr = '0;
    if (st_q == S_SEL && pick_any) clr[pick_idx] = 1'b1;
  end

  assign stat_cur = line_status_i[cur_q*DW +: DW];

  always_comb begin
    unique case (st_q)
      S_RD_IN:  word_off = AW'(OFF_IN_ST);
      S_RD_OUT: word_off = AW'(OFF_OUT_ST);
      default:  word_off = AW'(OFF_STATUS);
    endcase
  end

  assign mem_we_o    = (st_q == S_WR);
  assign mem_re_o    = (st_q == S_RD_IN) || (st_q == S_RD_OUT);
  assign mem_addr_o  = base_i + AW'(cur_q) * AW'(ENTRY_WORDS) + word_off;
  assign mem_wdata_o = stat_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= S_IDLE;
      snap_q       <= '0;
      cur_q        <= '0;
      in_q         <= 1'b0;
      out_q        <= 1'b0;
      disp_valid_o <= 1'b0;
      disp_line_o  <= '0;
      disp_dir_o   <= 1'b0;
      disp_state_o <= '0;
    end else begin
      disp_valid_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (tick && enable_i && (base_i != '0)) begin
          snap_q <= req;
          st_q   <= S_SEL;
        end
        S_SEL: if (pick_any) begin
          cur_q            <= pick_idx;
          snap_q[pick_idx] <= 1'b0;
          st_q             <= S_WR;
        end else begin
          st_q <= S_IDLE;
        end
        S_WR: begin
          in_q  <= stat_cur[ST_RXD];
          out_q <= stat_cur[ST_TXE];
          st_q  <= stat_cur[ST_RXD] ? S_RD_IN : (stat_cur[ST_TXE] ? S_RD_OUT : S_SEL);
        end
        S_RD_IN:  st_q <= S_WT_IN;
        S_WT_IN: begin
          if (mem_rdata_i != '0) begin
            disp_valid_o <= 1'b1;
            disp_line_o  <= cur_q;
            disp_dir_o   <= 1'b0;
            disp_state_o <= mem_rdata_i;
          end
          st_q <= out_q ? S_RD_OUT : S_SEL;
        end
        S_RD_OUT: st_q <= S_WT_OUT;
        S_WT_OUT: begin
          if (mem_rdata_i != '0) begin
            disp_valid_o <= 1'b1;
            disp_line_o  <= cur_q;
            disp_dir_o   <= 1'b1;
            disp_state_o <= mem_rdata_i;
          end
          st_q <= S_SEL;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  logic unused_in;
  assign unused_in = in_q;
endmodule

// File: rtl/lsc_scanner_chk.sv
module lsc_scanner_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic          disp_valid_o,
  input logic [DW-1:0] disp_state_o
);
  p_one_port_op_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  p_disp_after_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> $past(mem_re_o, 2));

  p_discard_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> (disp_state_o != '0));

  p_disp_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |=> !disp_valid_o);

  p_read_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> ($past(mem_we_o) || $past(mem_re_o, 2)));
endmodule

bind lsc_scanner lsc_scanner_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_lsc_scanner.sv
module sim_lsc_scanner;
  localparam int N = 8, AW = 16, DW = 16, P = 64;
  localparam logic [AW-1:0] BASE = 16'h0040;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cmd_we = 1'b0;
  logic [AW-1:0] base = '0;
  logic [N*DW-1:0] stat;
  logic [15:0] cmd = '0;
  logic mem_we, mem_re, disp_valid, disp_dir;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, rdata = '0, disp_state;
  logic [2:0] disp_line;

  logic [DW-1:0] mem [0:255];
  int n_chk = 0, n_fail = 0, ne = 0;
  int wr_line [0:63];
  int wr_n = 0, first_wr_ne = -1;
  int d_line [0:63];
  int d_dir [0:63];
  logic [DW-1:0] d_st [0:63];
  int d_n = 0;

  lsc_scanner #(.N_LINES(N), .AW(AW), .DW(DW), .SCAN_CYC(P)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .base_i(base),
    .line_status_i(stat), .cmd_we_i(cmd_we), .cmd_data_i(cmd),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(rdata),
    .disp_valid_o(disp_valid), .disp_line_o(disp_line),
    .disp_dir_o(disp_dir), .disp_state_o(disp_state)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) ne <= ne + 1;

  function automatic logic [DW-1:0] in_st(int l);
    return (l == 2 || l == 6) ? 16'h0 : 16'h0100 + 16'(l);
  endfunction
  function automatic logic [DW-1:0] out_st(int l);
    return (l == 0 || l == 5) ? 16'h0 : 16'h0200 + 16'(l);
  endfunction

  always @(negedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]] = mem_wdata;
      if (wr_n == 0) first_wr_ne = ne;
      if (wr_n < 64) wr_line[wr_n] = ((int'(mem_addr) - int'(BASE) - 1) % 6 == 0) ?
                                      (int'(mem_addr) - int'(BASE) - 1) / 6 : -1;
      wr_n++;
    end
    if (mem_re) rdata = mem[mem_addr[7:0]];
    if (disp_valid) begin
      if (d_n < 64) begin
        d_line[d_n] = int'(disp_line);
        d_dir[d_n] = int'(disp_dir);
        d_st[d_n] = disp_state;
      end
      d_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [N*DW-1:0] baseline();
    logic [N*DW-1:0] s;
    for (int l = 0; l < N; l++) s[l*DW +: DW] = 16'h000C | (16'(l) << 8);
    return s;
  endfunction

  task automatic wait_scan();
    do @(negedge clk); while (ne == 0 || (ne % P) != 0);
  endtask

  task automatic clear_logs();
    wr_n = 0; d_n = 0; first_wr_ne = -1;
    for (int l = 0; l < N; l++) mem[int'(BASE) + 6*l + 1] = '0;
  endtask

  task automatic settle();
    wait_scan(); repeat (56) @(negedge clk);
    stat = baseline();
    wait_scan(); repeat (56) @(negedge clk);
  endtask

  task automatic run_case(input logic [N*DW-1:0] s);
    wait_scan(); clear_logs(); stat = s; settle();
  endtask

  task automatic send_cmd(input logic [15:0] c);
    cmd = c; cmd_we = 1'b1;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  // exact ascending write list and the stored values
  task automatic check_writes(input logic [N-1:0] m, input logic [N*DW-1:0] s, input string req);
    int k = 0; bit ok = 1; bit vok = 1;
    for (int l = 0; l < N; l++) if (m[l]) begin
      if (k >= wr_n || wr_line[k] != l) ok = 0;
      if (mem[int'(BASE) + 6*l + 1] != s[l*DW +: DW]) vok = 0;
      k++;
    end
    chk(ok && wr_n == k, req, "status write sequence (count)", wr_n, k);
    chk(vok, req, "stored status values", int'(vok), 1);
  endtask

  task automatic check_disp(input logic [N*DW-1:0] s, input string req);
    int k = 0; bit ok = 1;
    for (int l = 0; l < N; l++) begin
      if (s[l*DW + 0] && in_st(l) != 0) begin
        if (k >= d_n || d_line[k] != l || d_dir[k] != 0 || d_st[k] != in_st(l)) ok = 0;
        k++;
      end
      if (s[l*DW + 1] && out_st(l) != 0) begin
        if (k >= d_n || d_line[k] != l || d_dir[k] != 1 || d_st[k] != out_st(l)) ok = 0;
        k++;
      end
    end
    chk(ok && d_n == k, req, "dispatch sequence (count)", d_n, k);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = '0;
    for (int l = 0; l < N; l++) begin
      mem[int'(BASE) + 6*l + 3] = in_st(l);
      mem[int'(BASE) + 6*l + 5] = out_st(l);
    end
    stat = baseline();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_we == 1'b0, "R1", "mem_we_o in reset", int'(mem_we), 0);
    chk(mem_re == 1'b0, "R1", "mem_re_o in reset", int'(mem_re), 0);
    chk(disp_valid == 1'b0, "R1", "disp_valid_o in reset", int'(disp_valid), 0);
    rst_n = 1'b1;

    // R2 disabled: no activity
    begin
      logic [N*DW-1:0] s = baseline();
      for (int l = 0; l < N; l++) s[l*DW + 0] = 1'b1;
      base = BASE; en = 1'b0;
      run_case(s);
      chk(wr_n == 0, "R2", "writes with enable_i=0", wr_n, 0);
      chk(d_n == 0, "R2", "dispatches with enable_i=0", d_n, 0);
      base = '0; en = 1'b1;
      run_case(s);
      chk(wr_n == 0, "R2", "writes with base_i=0", wr_n, 0);
      chk(d_n == 0, "R2", "dispatches with base_i=0", d_n, 0);
      base = BASE;
    end

    // R3 R6 R7 R8 R9 flag sweep across all lines
    for (int i = 0; i < 16; i++) begin
      logic [N*DW-1:0] s = baseline();
      logic [7:0] rx = (i == 15) ? 8'hFF : 8'((i * 37 + 3) & 255);
      logic [7:0] tx = (i == 15) ? 8'hFF : 8'((i * 101 + 17) & 255);
      for (int l = 0; l < N; l++) begin
        s[l*DW +: DW] = s[l*DW +: DW] | (16'(i) << 12);
        s[l*DW + 0] = rx[l];
        s[l*DW + 1] = tx[l];
      end
      run_case(s);
      check_writes(rx | tx, s, "R3/R4/R9");
      check_disp(s, "R6/R7/R8/R9");
      chk(first_wr_ne % P == 1, "R2", "first write edge offset in scan", first_wr_ne % P, 1);
    end

    // R4 falling indicator/carrier request; rising back requests nothing (R10)
    begin
      logic [N*DW-1:0] s = baseline();
      s[3*DW + 2] = 1'b0;
      s[1*DW + 3] = 1'b0;
      s[6*DW + 3] = 1'b0;
      run_case(s);
      check_writes(8'b0100_1010, s, "R4/R10");
      chk(d_n == 0, "R4", "no dispatch for edge-only request", d_n, 0);
    end

    // R5 single poke, served once (R10)
    wait_scan(); clear_logs();
    send_cmd(16'hC000 | (16'd5 << 9));
    settle();
    check_writes(8'b0010_0000, baseline(), "R5/R10");
    chk(d_n == 0, "R5", "no dispatch after poke", d_n, 0);

    // R5 poke every line
    wait_scan(); clear_logs();
    for (int l = 0; l < N; l++) send_cmd(16'hC000 | (16'(l) << 9));
    settle();
    check_writes(8'hFF, baseline(), "R5/R9");

    // R5 malformed commands have no effect
    wait_scan(); clear_logs();
    send_cmd(16'hC001 | (16'd2 << 9));
    send_cmd(16'h8000 | (16'd4 << 9));
    send_cmd(16'hD000);
    settle();
    chk(wr_n == 0, "R5", "writes after malformed commands", wr_n, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule